// File: doc/BRIEF.md
# PCIe Endpoint Reset Controller

This block produces the resets for the user logic that sits behind a PCIe endpoint. It combines three kinds of reset that reach different amounts of logic. The slot reset pin and the loss of transceiver clock lock are the fundamental reset. The in-band reset that the upstream port signals is the hot reset. Each function can also raise its own function-level reset (FLR). The first two kinds clear all of the user logic. An FLR clears only the registers that belong to the function that raised it.

The whole-logic reset asserts at once, without waiting for a clock edge. It is released through a short synchronizer, so it always falls in step with the user clock. When a function's FLR flag rises, the block holds that function's local reset for a minimum number of cycles. It then returns a one-cycle done pulse to the PCIe core and lets the function run again. A whole-logic reset that arrives during an FLR cancels it. No done pulse is sent for a cancelled FLR.

Top module: `pcie_ep_rst_ctrl`

## Requirements
- R1: The polarity of the slot reset pin is set by parameter `SLOT_RST_ACTIVE_HIGH`. With the default of 0, a low level on the pin asserts the reset and a high level releases it. With 1, a high level asserts the reset.
- R2: `user_rst` (high means reset) goes high as soon as any whole-logic source is active, with no clock edge needed. After every source goes inactive, `user_rst` stays high through the first rising clock edge and goes low at the second.
- R3: While `pll_locked` is low, `user_rst` stays high even when the slot reset is released. A drop of lock asserts `user_rst` at once.
- R4: `hot_rst_req` is level-sensitive. `user_rst` is high for as long as it is high, then releases with the same two-edge delay as in R2.
- R5: A rising `flr_active[i]` raises only `func_rst[i]`, at the third rising clock edge after the flag goes high. `user_rst` and the `func_rst` bits of the other functions stay low.
- R6: `func_rst[i]` stays high for exactly `MIN_HOLD` cycles (default 16) and then goes low. In that same cycle `flr_done[i]` is high, for exactly one cycle.
- R7: After `flr_done[i]`, no further function reset or done pulse occurs while `flr_active[i]` stays high. A new FLR starts only after the flag has been seen low and then high again.
- R8: Any whole-logic reset (slot, lock loss or hot reset) during an FLR cancels it, and `flr_done[i]` does not pulse for it. The function then starts no FLR until its flag has been seen low.
- R9: Whenever `user_rst` is high, every bit of `func_rst` is high too.
- R10: FLRs on different functions run independently. Flags raised in the same cycle give function resets and done pulses in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| slot_rst_pin | input | 1 | Slot reset from the edge connector, asynchronous; polarity set by parameter |
| pll_locked | input | 1 | Transceiver clock lock indication, asynchronous |
| hot_rst_req | input | 1 | Hot reset received from the upstream port, level-sensitive |
| flr_active | input | NUM_FUNCS | FLR in progress, one flag per function |
| user_rst | output | 1 | Whole-logic reset for the user logic, active high |
| func_rst | output | NUM_FUNCS | Function-local reset, one per function, active high |
| flr_done | output | NUM_FUNCS | One-cycle FLR completion pulse to the core, one per function |

## Verification
The bench times the exact cycle of each reset release and each function-reset edge. A synchronizer one stage short or long, or a release that is not synchronized, shifts these edges by a cycle, and the checks catch it. The bench also drives each asynchronous source halfway through a clock period and checks the output before the next edge, which exposes a synchronously asserted reset. The FLR tests count the length of the function reset and the width of the done pulse, and hold the flag high after completion. A miscounted hold, a pulse wider than one cycle, or a sequencer that restarts on a level instead of an edge all show up here. Slot and lock resets are applied in the middle of an FLR while its flag stays high. A design that still issues the done pulse, or restarts the FLR when the reset releases, fails these cases.

// File: rtl/pcie_rst_pkg.sv
package pcie_rst_pkg;

    typedef enum logic [1:0] {
        FLR_IDLE,
        FLR_HOLD,
        FLR_DONE,
        FLR_REARM
    } flr_state_e;

    typedef struct packed {
        logic slot;
        logic unlocked;
        logic hot;
    } rst_src_t;

    function automatic logic slot_is_active(input logic pin, input bit active_high);
        return active_high ? pin : ~pin;
    endfunction

    function automatic logic any_source(input rst_src_t s);
        return s.slot | s.unlocked | s.hot;
    endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic srst
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= '0;
        else      chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign srst = ~chain[STAGES-1];

    p_async_assert_r2: assert property (@(posedge clk) arst |-> srst)
        else $error("user reset not held while a source is active");

    p_sync_release_r2: assert property (@(posedge clk) disable iff (arst)
        $fell(srst) |-> $past(!arst))
        else $error("reset released without a quiet cycle");

endmodule

// File: rtl/level_sync.sv
module level_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        pipe[0] <= d;
        for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/flr_seq.sv
module flr_seq
    import pcie_rst_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flr_req,
    output logic hold_rst,
    output logic done
);
    localparam int CW = (MIN_HOLD < 2) ? 1 : $clog2(MIN_HOLD);

    flr_state_e     state;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FLR_REARM;
            cnt   <= '0;
        end else begin
            unique case (state)
                FLR_IDLE: begin
                    if (flr_req) begin
                        state <= FLR_HOLD;
                        cnt   <= '0;
                    end
                end
                FLR_HOLD: begin
                    if (cnt == CW'(MIN_HOLD - 1)) state <= FLR_DONE;
                    else                          cnt   <= cnt + 1'b1;
                end
                FLR_DONE:  state <= FLR_REARM;
                FLR_REARM: if (!flr_req) state <= FLR_IDLE;
                default:   state <= FLR_REARM;
            endcase
        end
    end

    assign hold_rst = (state == FLR_HOLD);
    assign done     = (state == FLR_DONE);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done pulse wider than one cycle");

    p_done_after_hold_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(hold_rst))
        else $error("done pulse without a preceding hold");

    p_abort_no_done_r8: assert property (@(posedge clk)
        $past(rst) |-> !done)
        else $error("done pulse right after a whole-logic reset");

endmodule

// File: rtl/pcie_ep_rst_ctrl.sv
module pcie_ep_rst_ctrl
    import pcie_rst_pkg::*;
#(
    parameter int NUM_FUNCS            = 2,
    parameter int MIN_HOLD             = 16,
    parameter int SYNC_STAGES          = 2,
    parameter bit SLOT_RST_ACTIVE_HIGH = 1'b0
) (
    input  logic                 clk,
    input  logic                 slot_rst_pin,
    input  logic                 pll_locked,
    input  logic                 hot_rst_req,
    input  logic [NUM_FUNCS-1:0] flr_active,
    output logic                 user_rst,
    output logic [NUM_FUNCS-1:0] func_rst,
    output logic [NUM_FUNCS-1:0] flr_done
);
    rst_src_t               src;
    logic                   whole_arst;
    logic [NUM_FUNCS-1:0]   flr_req;

    assign src.slot     = slot_is_active(slot_rst_pin, SLOT_RST_ACTIVE_HIGH);
    assign src.unlocked = ~pll_locked;
    assign src.hot      = hot_rst_req;
    assign whole_arst   = any_source(src);

    rst_release_sync #(.STAGES(SYNC_STAGES)) u_user_rst (
        .clk  (clk),
        .arst (whole_arst),
        .srst (user_rst)
    );

    level_sync #(.WIDTH(NUM_FUNCS), .STAGES(SYNC_STAGES)) u_flr_sync (
        .clk (clk),
        .d   (flr_active),
        .q   (flr_req)
    );

    for (genvar g = 0; g < NUM_FUNCS; g++) begin : g_func
        logic hold;
        logic done;

        flr_seq #(.MIN_HOLD(MIN_HOLD)) u_seq (
            .clk      (clk),
            .rst      (user_rst),
            .flr_req  (flr_req[g]),
            .hold_rst (hold),
            .done     (done)
        );

        assign func_rst[g] = user_rst | hold;
        assign flr_done[g] = done;
    end

    p_slot_holds_r1: assert property (@(posedge clk)
        slot_is_active(slot_rst_pin, SLOT_RST_ACTIVE_HIGH) |-> user_rst)
        else $error("slot reset active but user logic released");

    p_lock_holds_r3: assert property (@(posedge clk)
        !pll_locked |-> user_rst)
        else $error("lock low but user logic released");

    p_hot_holds_r4: assert property (@(posedge clk)
        hot_rst_req |-> user_rst)
        else $error("hot reset active but user logic released");

    p_done_not_in_reset_r8: assert property (@(posedge clk)
        user_rst |-> (flr_done == '0))
        else $error("FLR done issued during whole-logic reset");

endmodule

// File: tb/pcie_ep_rst_ctrl_tb_top.sv
module pcie_ep_rst_ctrl_tb_top;

    localparam int NF   = 2;
    localparam int HOLD = 16;

    logic          clk = 1'b0;
    logic          slot_n = 1'b0;
    logic          slot_hi = 1'b1;
    logic          lock = 1'b0;
    logic          hot = 1'b0;
    logic          hot_hi = 1'b0;
    logic [NF-1:0] flr = '0;
    logic [NF-1:0] flr_hi = '0;

    logic          user_rst, user_rst_hi;
    logic [NF-1:0] func_rst, func_rst_hi;
    logic [NF-1:0] flr_done, flr_done_hi;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcie_ep_rst_ctrl #(.NUM_FUNCS(NF), .MIN_HOLD(HOLD)) dut_i (
        .clk(clk), .slot_rst_pin(slot_n), .pll_locked(lock), .hot_rst_req(hot),
        .flr_active(flr), .user_rst(user_rst), .func_rst(func_rst), .flr_done(flr_done)
    );

    pcie_ep_rst_ctrl #(.NUM_FUNCS(NF), .MIN_HOLD(HOLD), .SLOT_RST_ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .slot_rst_pin(slot_hi), .pll_locked(lock), .hot_rst_req(hot_hi),
        .flr_active(flr_hi), .user_rst(user_rst_hi), .func_rst(func_rst_hi), .flr_done(flr_done_hi)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        tick(4);
        chk("R2", "user_rst in reset", user_rst, 1);
        chk("R9", "func_rst in reset", func_rst, 2'b11);
        chk("R8", "flr_done in reset", flr_done, 0);
        lock = 1'b1;
        tick(4);
        chk("R1", "slot low still resets default part", user_rst, 1);
        chk("R1", "slot high resets active-high part", user_rst_hi, 1);
    endtask

    task automatic t_release();
        slot_n = 1'b1;
        slot_hi = 1'b0;
        tick(1);
        chk("R2", "held after first edge", user_rst, 1);
        chk("R1", "active-high held after first edge", user_rst_hi, 1);
        tick(1);
        chk("R2", "released at second edge", user_rst, 0);
        chk("R1", "active-high released", user_rst_hi, 0);
        chk("R9", "func_rst released", func_rst, 0);
        tick(3);
        slot_n = 1'b0;
        #1;
        chk("R2", "asynchronous assert", user_rst, 1);
        chk("R1", "other part ignores its low pin", user_rst_hi, 0);
        tick(2);
        slot_n = 1'b1;
        tick(2);
        chk("R2", "release after reassert", user_rst, 0);
        slot_hi = 1'b1;
        #1;
        chk("R1", "active-high async assert", user_rst_hi, 1);
        tick(1);
        slot_hi = 1'b0;
        tick(3);
    endtask

    task automatic t_lock();
        lock = 1'b0;
        #1;
        chk("R3", "lock loss asserts at once", user_rst, 1);
        tick(5);
        chk("R3", "held while unlocked", user_rst, 1);
        lock = 1'b1;
        tick(1);
        chk("R3", "held one edge after relock", user_rst, 1);
        tick(1);
        chk("R3", "released after relock", user_rst, 0);
        tick(3);
    endtask

    task automatic t_hot();
        hot = 1'b1;
        #1;
        chk("R4", "hot reset asserts", user_rst, 1);
        tick(6);
        chk("R4", "held while hot reset high", user_rst, 1);
        chk("R9", "func_rst under hot reset", func_rst, 2'b11);
        hot = 1'b0;
        tick(1);
        chk("R4", "held one edge after hot", user_rst, 1);
        tick(1);
        chk("R4", "released after hot", user_rst, 0);
        chk("R1", "hot on one part leaves other", user_rst_hi, 0);
        tick(3);
    endtask

    task automatic flr_cycle(input logic [NF-1:0] mask, input string req, input int extra);
        int cnt;
        flr = flr | mask;
        tick(2);
        chk(req, "no func reset before sync", func_rst & mask, 0);
        tick(1);
        chk("R5", "func reset at third edge", func_rst, mask);
        chk("R5", "user_rst stays low in FLR", user_rst, 0);
        cnt = 1;
        for (int i = 0; i < 100 && (func_rst & mask) == mask; i++) begin
            if (flr_done !== '0) chk(req, "early done", flr_done, 0);
            tick(1);
            if ((func_rst & mask) == mask) cnt++;
        end
        chk("R6", "hold length", cnt, HOLD);
        chk(req, "done with release", flr_done, mask);
        tick(1);
        chk("R6", "done one cycle", flr_done, 0);
        for (int i = 0; i < extra; i++) begin
            tick(1);
            if (func_rst !== '0 || flr_done !== '0) chk("R7", "quiet while flag high", {func_rst, flr_done}, 0);
        end
        if (extra > 0) chk("R7", "no restart on held flag", {func_rst, flr_done}, 0);
        flr = flr & ~mask;
        tick(4);
    endtask

    task automatic t_abort_slot();
        int dones = 0;
        flr[0] = 1'b1;
        tick(8);
        chk("R8", "FLR running before abort", func_rst[0], 1);
        slot_n = 1'b0;
        tick(3);
        slot_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (flr_done != '0) dones++;
        end
        chk("R8", "no done after slot abort", dones, 0);
        chk("R8", "no restart while flag high", func_rst[0], 0);
        flr[0] = 1'b0;
        tick(4);
        flr_cycle(2'b01, "R8", 0);
    endtask

    task automatic t_abort_lock();
        int dones = 0;
        flr[1] = 1'b1;
        tick(8);
        lock = 1'b0;
        tick(2);
        lock = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (flr_done != '0) dones++;
        end
        chk("R8", "no done after lock abort", dones, 0);
        chk("R8", "func 1 quiet after abort", func_rst[1], 0);
        flr[1] = 1'b0;
        tick(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_release();
        t_lock();
        t_hot();
        flr_cycle(2'b01, "R5", 0);
        flr_cycle(2'b10, "R7", 10);
        flr_cycle(2'b11, "R10", 0);
        t_abort_slot();
        t_abort_lock();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule